// File: doc/BRIEF.md
# Sample-RAM Block DMA Engine

This block moves one block of bytes between a host-side byte stream and a 20-bit byte-addressed local sample RAM. Software sets a start address register, held in 16-byte paragraphs, and a separate low-nibble register that gives byte granularity. It then writes the control register with the request bit set. The engine streams the block: from host to RAM, one byte for each accepted host byte, or from RAM to host, one byte for each RAM read.

On a 16-bit channel the RAM address is remapped: the top two address bits stay, and the remaining paragraph bits are doubled. Samples going to RAM can have their sign bit flipped, either on every byte or only on the high byte of each 16-bit pair. When the whole block is done, the engine advances the address registers by the block length and drops the request bit. If enabled, it raises a terminal-count interrupt. That interrupt is acknowledged by reading the control register.

Top module: `smpdma_top`

## Requirements
- R1: After reset the control register, start register, low-nibble register and terminal-count flag are zero, `irq` and `dma_active` are low, and neither `ram_we` nor `ram_re` is asserted.
- R2: Register writes use `reg_sel` 0 for control (8 bits), 1 for start (16 bits) and 2 for low nibble (8 bits). The effective byte address is start*16 + low-nibble[3:0], and byte k of a block goes to effective address + k, modulo 2^20.
- R3: With `wide_chan` high at the start of a block, the base address is {eff[19:18], eff[16:4], 5'b00000}. This keeps bits 19:18 and replaces the rest with twice (eff AND 0x1FFF0). Byte k then goes to base + k.
- R4: In a host-to-RAM block with control bit 7 set and bit 6 clear, every byte is written with bit 7 inverted (XOR 0x80).
- R5: In a host-to-RAM block with control bits 7 and 6 set, even-indexed bytes (pair low bytes) are written unchanged and odd-indexed bytes (pair high bytes) are written XOR 0x80.
- R6: At the end of a block of N bytes, the start register becomes start + (N >> 4) modulo 2^16. The low-nibble register becomes (N + old nibble[3:0]) mod 16, with its upper four bits zero. There is no carry from the nibble into the start register.
- R7: Writing the start register clears bits 7:4 of the low-nibble register and leaves bits 3:0 unchanged.
- R8: Writing control (sel 0) with bit 0 set starts a block of `xfer_len` bytes; bit 1 = 1 selects RAM to host. `dma_active` mirrors control bit 0, which clears on the clock edge that completes the last byte. Only on that edge, and only if control bit 5 is set, does the terminal-count flag and `irq` rise. `irq` stays low while the block is partly done.
- R9: `ctrl_rdata` shows the control register with bit 6 replaced by the terminal-count flag. A `ctrl_rd` strobe clears control bits 6 and 2 and the terminal-count flag, so `irq` falls on that edge.
- R10: In a RAM-to-host block, RAM is read at base + k in increasing k. Each byte appears on `host_out_data` with `host_out_valid` one cycle after its read, never inverted, even with bit 7 set, and RAM is never written.
- R11: A block with `xfer_len` = 0 makes no RAM access, leaves the start and low-nibble registers unchanged, and clears control bit 0 one cycle after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 low nibble |
| reg_wdata | input | 16 | Register write data |
| ctrl_rd | input | 1 | Control read strobe (read side effects) |
| ctrl_rdata | output | 8 | Control read data, bit 6 = terminal count pending |
| wide_chan | input | 1 | 16-bit channel address translation, sampled at start |
| xfer_len | input | 16 | Block length in bytes, sampled at start |
| host_in_valid | input | 1 | Host byte available (host to RAM) |
| host_in_data | input | 8 | Host byte |
| host_out_valid | output | 1 | Byte to host valid (RAM to host) |
| host_out_data | output | 8 | Byte to host |
| ram_addr | output | 20 | Sample RAM byte address |
| ram_we | output | 1 | Sample RAM write enable |
| ram_wdata | output | 8 | Sample RAM write data |
| ram_re | output | 1 | Sample RAM read enable, data returned next cycle |
| ram_rdata | input | 8 | Sample RAM read data |
| dma_active | output | 1 | Control bit 0, request/busy |
| start_addr | output | 16 | Start register (paragraphs) |
| nib_reg | output | 8 | Low-nibble register |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The bench attacks the address arithmetic at its edges. One block starts eight bytes below the top of RAM and crosses the 2^20 wrap. Another starts just below the 16-bit limit of the start register and checks its wrap. A third uses a nibble and length whose sum overflows 16; a design that carried the nibble into the start register, or kept the nibble's upper bits, would show wrong register values. Host bytes arrive with gaps, and `irq` is sampled in those gaps: a design that signalled terminal count per byte or per chunk would raise `irq` early. The bench also checks the inversion pattern for 8-bit data, for 16-bit data and for RAM-to-host blocks, the translated addresses of the 16-bit channel, the return value and side effects of the control read, and a zero-length block that must make no RAM access at all.

// File: rtl/smpdma_pkg.sv
package smpdma_pkg;
   localparam int CB_REQ   = 0;
   localparam int CB_DIR   = 1;
   localparam int CB_RDCLR = 2;
   localparam int CB_TCIE  = 5;
   localparam int CB_D16   = 6;
   localparam int CB_INV   = 7;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_START = 2'd1,
      SEL_NIB   = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   function automatic logic [7:0] sign_mask(input logic inv, input logic d16, input logic hi);
      return (inv && (!d16 || hi)) ? 8'h80 : 8'h00;
   endfunction
endpackage

// File: rtl/smpdma_regs.sv
module smpdma_regs
   import smpdma_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int START_W = 16,
   parameter int LEN_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [1:0]         sel_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic               rd_i,
   input  logic               busy_i,
   input  logic               done_i,
   input  logic [LEN_W-1:0]   done_len_i,
   output logic [7:0]         ctrl_o,
   output logic [START_W-1:0] start_o,
   output logic [7:0]         nib_o,
   output logic               tc_o,
   output logic [7:0]         rdata_o
);
   logic [7:0]         ctrl_q;
   logic [START_W-1:0] start_q;
   logic [7:0]         nib_q;
   logic               tc_q;
   logic [3:0]         nib_sum;
   logic [START_W-1:0] start_step;

   initial begin
      assert (START_W <= REG_W) else $error("start register wider than write bus");
      assert (LEN_W >= 4) else $error("length too narrow");
   end

   assign nib_sum    = nib_q[3:0] + done_len_i[3:0];
   assign start_step = START_W'(done_len_i >> 4);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= 8'h00;
         start_q <= '0;
         nib_q   <= 8'h00;
         tc_q    <= 1'b0;
      end else if (done_i) begin
         ctrl_q[CB_REQ] <= 1'b0;
         start_q        <= start_q + start_step;
         nib_q          <= {4'h0, nib_sum};
         if (ctrl_q[CB_TCIE]) tc_q <= 1'b1;
      end else begin
         if (wr_i) begin
            if (sel_i == SEL_CTRL && !busy_i) begin
               ctrl_q <= wdata_i[7:0];
            end else if (sel_i == SEL_START) begin
               start_q    <= wdata_i[START_W-1:0];
               nib_q[7:4] <= 4'h0;
            end else if (sel_i == SEL_NIB) begin
               nib_q <= wdata_i[7:0];
            end
         end
         if (rd_i) begin
            ctrl_q[CB_D16]   <= 1'b0;
            ctrl_q[CB_RDCLR] <= 1'b0;
            tc_q             <= 1'b0;
         end
      end
   end

   assign rdata_o = {ctrl_q[7], tc_q, ctrl_q[5:0]};
   assign ctrl_o  = ctrl_q;
   assign start_o = start_q;
   assign nib_o   = nib_q;
   assign tc_o    = tc_q;

   // R6
   start_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> start_q == $past(start_q) + START_W'($past(done_len_i) >> 4));
   // R7
   nib_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == SEL_START && !done_i) |=> nib_q[7:4] == 4'h0);
   // R8
   tc_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_q) |-> $past(done_i && ctrl_q[CB_TCIE]));
   // R9
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !done_i && !wr_i) |=> (!tc_q && !ctrl_q[CB_RDCLR] && !ctrl_q[CB_D16]));
endmodule

// File: rtl/smpdma_addr.sv
module smpdma_addr #(
   parameter int AW      = 20,
   parameter int START_W = 16,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [START_W-1:0] start_i,
   input  logic [3:0]         nib_i,
   input  logic               wide_i,
   output logic [AW-1:0]      base_o
);
   localparam int PARA_W = AW - 7;
   logic [AW-1:0] eff;

   initial begin
      assert (START_W + 4 == AW) else $error("start width must be address width minus 4");
      assert (AW >= 8) else $error("address too narrow");
   end

   assign eff = {start_i, 4'h0} + AW'(nib_i);

   generate
      if (WIDE_EN) begin : g_wide
         logic [AW-1:0] xl;
         logic [PARA_W-1:0] para;
         assign para   = eff[AW-4:4];
         assign xl     = {eff[AW-1:AW-2], para, 5'b00000};
         assign base_o = wide_i ? xl : eff;
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide_i;
         assign base_o      = eff;
      end
   endgenerate
endmodule

// File: rtl/smpdma_xfer.sv
module smpdma_xfer
   import smpdma_pkg::*;
#(
   parameter int AW    = 20,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic             go_dir_i,
   input  logic             go_inv_i,
   input  logic             go_d16_i,
   input  logic [AW-1:0]    go_base_i,
   input  logic [LEN_W-1:0] go_len_i,
   input  logic             host_in_valid_i,
   input  logic [7:0]       host_in_data_i,
   output logic             host_out_valid_o,
   output logic [7:0]       host_out_data_o,
   output logic [AW-1:0]    ram_addr_o,
   output logic             ram_we_o,
   output logic [7:0]       ram_wdata_o,
   output logic             ram_re_o,
   input  logic [7:0]       ram_rdata_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [LEN_W-1:0] len_o
);
   logic             busy_q, dir_q, inv_q, d16_q;
   logic [AW-1:0]    base_q;
   logic [LEN_W-1:0] len_q, idx_q;
   logic             rdv_q, rdlast_q;
   logic             more, is_last, acc_w, iss_r;

   initial begin
      assert (LEN_W <= AW) else $error("length wider than address");
   end

   assign more    = idx_q < len_q;
   assign is_last = idx_q == len_q - LEN_W'(1);
   assign acc_w   = busy_q && !dir_q && host_in_valid_i && more;
   assign iss_r   = busy_q && dir_q && more;
   assign done_o  = busy_q && ((len_q == '0) || (acc_w && is_last) || (dir_q && rdv_q && rdlast_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         dir_q    <= 1'b0;
         inv_q    <= 1'b0;
         d16_q    <= 1'b0;
         base_q   <= '0;
         len_q    <= '0;
         idx_q    <= '0;
         rdv_q    <= 1'b0;
         rdlast_q <= 1'b0;
      end else if (go_i && !busy_q) begin
         busy_q   <= 1'b1;
         dir_q    <= go_dir_i;
         inv_q    <= go_inv_i;
         d16_q    <= go_d16_i;
         base_q   <= go_base_i;
         len_q    <= go_len_i;
         idx_q    <= '0;
         rdv_q    <= 1'b0;
         rdlast_q <= 1'b0;
      end else if (busy_q) begin
         if (acc_w || iss_r) idx_q <= idx_q + LEN_W'(1);
         rdv_q    <= iss_r;
         rdlast_q <= iss_r && is_last;
         if (done_o) busy_q <= 1'b0;
      end
   end

   assign ram_addr_o       = base_q + AW'(idx_q);
   assign ram_we_o         = acc_w;
   assign ram_re_o         = iss_r;
   assign ram_wdata_o      = host_in_data_i ^ sign_mask(inv_q, d16_q, idx_q[0]);
   assign host_out_valid_o = rdv_q;
   assign host_out_data_o  = ram_rdata_i;
   assign busy_o           = busy_q;
   assign len_o            = len_q;

   // R10
   out_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_out_valid_o |-> $past(ram_re_o));
   // R8
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_q);
   // R11
   zero_len_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && len_q == '0) |-> (!ram_we_o && !ram_re_o));
   // R10
   rd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && dir_q) |-> !ram_we_o);
endmodule

// File: rtl/smpdma_top.sv
module smpdma_top
   import smpdma_pkg::*;
#(
   parameter int AW      = 20,
   parameter int LEN_W   = 16,
   parameter int REG_W   = 16,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             ctrl_rd,
   output logic [7:0]       ctrl_rdata,
   input  logic             wide_chan,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             host_in_valid,
   input  logic [7:0]       host_in_data,
   output logic             host_out_valid,
   output logic [7:0]       host_out_data,
   output logic [AW-1:0]    ram_addr,
   output logic             ram_we,
   output logic [7:0]       ram_wdata,
   output logic             ram_re,
   input  logic [7:0]       ram_rdata,
   output logic             dma_active,
   output logic [AW-5:0]    start_addr,
   output logic [7:0]       nib_reg,
   output logic             irq
);
   localparam int START_W = AW - 4;

   logic [7:0]         ctrl_q;
   logic [START_W-1:0] start_q;
   logic [7:0]         nib_q;
   logic               tc_q, busy, done, go;
   logic [AW-1:0]      base;
   logic [LEN_W-1:0]   len_q;

   assign go = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[CB_REQ] && !busy;

   smpdma_regs #(.REG_W(REG_W), .START_W(START_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .sel_i(reg_sel), .wdata_i(reg_wdata),
      .rd_i(ctrl_rd), .busy_i(busy), .done_i(done), .done_len_i(len_q),
      .ctrl_o(ctrl_q), .start_o(start_q), .nib_o(nib_q), .tc_o(tc_q), .rdata_o(ctrl_rdata)
   );

   smpdma_addr #(.AW(AW), .START_W(START_W), .WIDE_EN(WIDE_EN)) u_addr (
      .start_i(start_q), .nib_i(nib_q[3:0]), .wide_i(wide_chan), .base_o(base)
   );

   smpdma_xfer #(.AW(AW), .LEN_W(LEN_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .go_i(go),
      .go_dir_i(reg_wdata[CB_DIR]), .go_inv_i(reg_wdata[CB_INV] && !reg_wdata[CB_DIR]),
      .go_d16_i(reg_wdata[CB_D16]), .go_base_i(base), .go_len_i(xfer_len),
      .host_in_valid_i(host_in_valid), .host_in_data_i(host_in_data),
      .host_out_valid_o(host_out_valid), .host_out_data_o(host_out_data),
      .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
      .ram_re_o(ram_re), .ram_rdata_i(ram_rdata),
      .busy_o(busy), .done_o(done), .len_o(len_q)
   );

   assign dma_active = ctrl_q[CB_REQ];
   assign start_addr = start_q;
   assign nib_reg    = nib_q;
   assign irq        = tc_q;

   // R8
   active_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> dma_active);
   // R1
   idle_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_active |-> (!ram_we && !ram_re));
endmodule

// File: tb/smpdma_top_tb.sv
`timescale 1ns/1ps
module smpdma_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [15:0] reg_wdata = 16'h0;
   logic        ctrl_rd = 1'b0;
   logic [7:0]  ctrl_rdata;
   logic        wide_chan = 1'b0;
   logic [15:0] xfer_len = 16'h0;
   logic        host_in_valid = 1'b0;
   logic [7:0]  host_in_data = 8'h0;
   logic        host_out_valid;
   logic [7:0]  host_out_data;
   logic [19:0] ram_addr;
   logic        ram_we, ram_re;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = 8'h0;
   logic        dma_active;
   logic [15:0] start_addr;
   logic [7:0]  nib_reg;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [7:0] mem [int unsigned];

   always #4 clk = ~clk;

   smpdma_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ctrl_rd(ctrl_rd), .ctrl_rdata(ctrl_rdata), .wide_chan(wide_chan), .xfer_len(xfer_len),
      .host_in_valid(host_in_valid), .host_in_data(host_in_data),
      .host_out_valid(host_out_valid), .host_out_data(host_out_data),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_re(ram_re),
      .ram_rdata(ram_rdata), .dma_active(dma_active), .start_addr(start_addr),
      .nib_reg(nib_reg), .irq(irq)
   );

   always @(posedge clk) begin
      if (ram_we) mem[int'(ram_addr)] = ram_wdata;
      if (ram_re) ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input logic [7:0] seed);
      return 8'(k * 37) + seed;
   endfunction

   function automatic logic [19:0] exp_base(input logic [15:0] st, input logic [7:0] nb, input bit wide);
      logic [19:0] eff;
      eff = {st, 4'h0} + {16'h0, nb[3:0]};
      if (wide) return {eff[19:18], 13'(eff[16:4]), 5'b0};
      return eff;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic rd_ctrl(output logic [7:0] v);
      ctrl_rd = 1'b1;
      #1 v = ctrl_rdata;
      @(negedge clk);
      ctrl_rd = 1'b0;
   endtask

   task automatic h2r(input logic [15:0] st, input logic [7:0] nb, input logic [7:0] ctl,
                      input bit wide, input int len, input bit gaps, input logic [7:0] seed,
                      input string tag);
      logic [19:0] b, a;
      logic [7:0] m;
      int nbytes;
      mem.delete();
      wr(2'd1, st); wr(2'd2, {8'h0, nb});
      wide_chan = wide; xfer_len = 16'(len);
      wr(2'd0, {8'h0, ctl});
      for (int k = 0; k < len; k++) begin
         if (gaps && (k % 3 == 1)) begin
            host_in_valid = 1'b0;
            @(negedge clk);
            chk(irq == 1'b0, {tag, " R8 no irq mid-block"}, irq, 0);
         end
         host_in_valid = 1'b1; host_in_data = pat(k, seed);
         @(negedge clk);
      end
      host_in_valid = 1'b0;
      chk(dma_active == 1'b0, {tag, " R8 request cleared at end"}, dma_active, 0);
      b = exp_base(st, nb, wide);
      for (int k = 0; k < len; k++) begin
         a = b + 20'(k);
         m = (ctl[7] && (!ctl[6] || k[0])) ? 8'h80 : 8'h00;
         chk(mem.exists(int'(a)) && mem[int'(a)] == (pat(k, seed) ^ m), {tag, " data/addr"},
             mem.exists(int'(a)) ? {12'h0, a, mem[int'(a)]} : 32'hDEAD, {12'h0, a, pat(k, seed) ^ m});
      end
      nbytes = mem.num();
      chk(nbytes == len, {tag, " R2 byte count"}, nbytes, len);
      chk(start_addr == st + 16'(len >> 4), {tag, " R6 start advance"}, start_addr, st + 16'(len >> 4));
      chk(nib_reg == {4'h0, nb[3:0] + 4'(len)}, {tag, " R6 nibble"}, nib_reg, {4'h0, nb[3:0] + 4'(len)});
   endtask

   task automatic t_reset;
      chk(irq == 0 && dma_active == 0, "R1 irq/active", {irq, dma_active}, 0);
      chk(start_addr == 0 && nib_reg == 0, "R1 addr regs", {start_addr, nib_reg}, 0);
      chk(ctrl_rdata == 0, "R1 control", ctrl_rdata, 0);
      chk(ram_we == 0 && ram_re == 0 && host_out_valid == 0, "R1 ram idle", {ram_we, ram_re}, 0);
   endtask

   task automatic t_tc;
      logic [7:0] v;
      h2r(16'h0600, 8'h01, 8'h21, 1'b0, 6, 1'b1, 8'h11, "tc");
      chk(irq == 1'b1, "R8 irq at end", irq, 1);
      rd_ctrl(v);
      chk(v == 8'h60, "R9 read shows tc in bit6", v, 8'h60);
      chk(irq == 1'b0, "R9 irq dropped by read", irq, 0);
      rd_ctrl(v);
      chk(v == 8'h20, "R9 tc cleared", v, 8'h20);
   endtask

   task automatic t_rdclr;
      logic [7:0] v;
      wr(2'd0, 16'h0044);
      rd_ctrl(v);
      chk(v == 8'h04, "R9 first read", v, 8'h04);
      rd_ctrl(v);
      chk(v == 8'h00, "R9 bit2 cleared", v, 8'h00);
   endtask

   task automatic t_nibclr;
      wr(2'd2, 16'h00A7);
      chk(nib_reg == 8'hA7, "R7 nibble written", nib_reg, 8'hA7);
      wr(2'd1, 16'h0010);
      chk(nib_reg == 8'h07, "R7 start write clears upper nibble", nib_reg, 8'h07);
      chk(start_addr == 16'h0010, "R7 start written", start_addr, 16'h0010);
   endtask

   task automatic t_r2h;
      logic [19:0] b;
      int n, nbytes;
      mem.delete();
      wr(2'd1, 16'h0400); wr(2'd2, 16'h0003);
      wide_chan = 1'b0; xfer_len = 16'd9;
      b = exp_base(16'h0400, 8'h03, 1'b0);
      for (int k = 0; k < 9; k++) mem[int'(b + 20'(k))] = pat(k, 8'hC5);
      wr(2'd0, 16'h0083);
      n = 0;
      for (int c = 0; c < 40; c++) begin
         if (host_out_valid) begin
            chk(n < 9 && host_out_data == pat(n, 8'hC5), "R10 byte order, no inversion",
                host_out_data, pat(n, 8'hC5));
            n++;
         end
         if (!dma_active) break;
         @(negedge clk);
      end
      chk(n == 9, "R10 byte count", n, 9);
      chk(dma_active == 1'b0, "R10 block finished", dma_active, 0);
      nbytes = mem.num();
      chk(nbytes == 9, "R10 RAM not written", nbytes, 9);
      chk(start_addr == 16'h0400 && nib_reg == 8'h0C, "R6 r2h advance", {start_addr, nib_reg}, 24'h04000C);
   endtask

   task automatic t_zero;
      mem.delete();
      wr(2'd1, 16'h0500); wr(2'd2, 16'h0004);
      xfer_len = 16'd0;
      wr(2'd0, 16'h0001);
      chk(ram_we == 0 && ram_re == 0, "R11 no RAM access", {ram_we, ram_re}, 0);
      @(negedge clk);
      chk(dma_active == 1'b0, "R11 completes", dma_active, 0);
      chk(start_addr == 16'h0500 && nib_reg == 8'h04, "R11 regs unchanged", {start_addr, nib_reg}, 24'h050004);
      chk(mem.num() == 0, "R11 nothing written", mem.num(), 0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      h2r(16'h0123, 8'h05, 8'h01, 1'b0, 20, 1'b1, 8'h3C, "R2 plain");
      h2r(16'h0200, 8'h0F, 8'h81, 1'b0, 7, 1'b0, 8'h5A, "R4 invert8");
      h2r(16'h0300, 8'h00, 8'hC1, 1'b0, 8, 1'b0, 8'h01, "R5 invert16");
      h2r(16'hC123, 8'h02, 8'h01, 1'b1, 5, 1'b0, 8'h77, "R3 wide");
      h2r(16'hFFFF, 8'h08, 8'h01, 1'b0, 40, 1'b0, 8'h90, "R6 wrap");
      t_tc();
      t_rdclr();
      t_nibclr();
      t_r2h();
      t_zero();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule